// File: doc/BRIEF.md
# Matrix Keypad Scanner with Hex Digit Display

The block scans a 4x4 matrix of passive switches. It drives one row low at a time and senses the four pulled-up column lines. A clock divider sets the length of each row slot. At the end of a slot the block samples the columns. If exactly one column reads low, it forms a 4-bit key code from the row index and the encoded column position. It latches that code, pulses a one-cycle key strobe and shows the code as a hex digit on a seven-segment output.

A single retriggerable mask timer serves all sixteen keys. Once a key has been accepted, scanning stays on that row and no new key can be accepted. This lasts until the columns have read high for a set number of consecutive slot samples, so bounce on both press and release is absorbed. A pattern with two or more low columns in the same slot is rejected. The column inputs pass through a synchronizer first. The slot length must be longer than the synchronizer depth.

Top module: `kpad_scan`

## Requirements
- R1: While rst_ni is low and just after its release: row_no_o is 4'b1110 (row 0 driven), key_o is 0, key_stb_o is 0 and seg_o is 8'h80.
- R2: With no key pressed, exactly one bit of row_no_o is low. The low bit steps through rows 0, 1, 2, 3 and back to 0, holding each row for SCAN_DIV clock cycles. After the k-th rising edge following reset release, the driven row is (k / SCAN_DIV) mod 4.
- R3: Columns are active low (bit c of col_ni low means column c is pressed). When exactly one column reads low at the end of a row slot, the accepted code is {row[1:0], col[1:0]}, where col is the position of the low bit.
- R4: key_stb_o is high for exactly one cycle per accepted key. key_o and seg_o take their new values in the same cycle that the strobe is high.
- R5: From the accepted slot until the mask ends, row_no_o stays on the row of the accepted key.
- R6: After a key is accepted, no further key is accepted until the columns have read all high at MASK_TICKS consecutive slot ends. A low column at any slot end restarts that count, so bounce shorter than the window gives no second strobe.
- R7: A slot end with two or more low columns gives no strobe and leaves key_o unchanged, and scanning continues through all rows.
- R8: seg_o is active high in bit order h g f e d c b a (bit 7 = h, the decimal point). Hex digits map 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71.
- R9: Until the first key is accepted the code is invalid, and seg_o lights only the h segment (8'h80).
- R10: key_o and seg_o hold their values until the next accepted key, including after the key is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| col_ni | input | 4 | Column sense lines, pulled up, low when pressed |
| row_no_o | output | 4 | Row drive, one bit low at a time |
| key_o | output | 4 | Latched key code {row, column} |
| key_stb_o | output | 1 | One-cycle strobe when a key is accepted |
| seg_o | output | 8 | Seven-segment pattern, hgfedcba, active high |

## Verification
A stuck or skipped row counter shows on row_no_o within one slot and corrupts the row half of key_o at the next strobe. A wrong column encoder or a wrong segment table shows as a bad key_o or seg_o in the very cycle of the strobe. A mask that ends early, or one that restarts wrongly, shows as an extra strobe during bounce, or as no second acceptance after release, within a few slots. A scan that does not pause shows as row_no_o moving while a key is held.

// File: rtl/kpad_pkg.sv
package kpad_pkg;

  typedef enum logic {
    ST_SCAN = 1'b0,
    ST_MASK = 1'b1
  } kpad_state_e;

  localparam logic [7:0] SEG_DP_ONLY = 8'h80;

  // hgfedcba, active high
  function automatic logic [7:0] hex_to_seg(input logic [3:0] v);
    logic [7:0] s;
    case (v)
      4'h0: s = 8'h3F;
      4'h1: s = 8'h06;
      4'h2: s = 8'h5B;
      4'h3: s = 8'h4F;
      4'h4: s = 8'h66;
      4'h5: s = 8'h6D;
      4'h6: s = 8'h7D;
      4'h7: s = 8'h07;
      4'h8: s = 8'h7F;
      4'h9: s = 8'h6F;
      4'hA: s = 8'h77;
      4'hB: s = 8'h7C;
      4'hC: s = 8'h39;
      4'hD: s = 8'h5E;
      4'hE: s = 8'h79;
      default: s = 8'h71;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/kpad_tick_gen.sv
module kpad_tick_gen #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/kpad_row_scan.sv
module kpad_row_scan #(
  parameter int unsigned ROWS = 4,
  localparam int unsigned RW  = $clog2(ROWS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            hold_i,
  output logic [RW-1:0]   row_idx_o,
  output logic [ROWS-1:0] row_no_o
);
  localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

  logic [RW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (tick_i && !hold_i) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_dec
    assign row_no_o[r] = (idx_q != RW'(r));
  end

  assign row_idx_o = idx_q;
endmodule

// File: rtl/kpad_col_enc.sv
module kpad_col_enc #(
  parameter int unsigned COLS = 4,
  localparam int unsigned CW  = $clog2(COLS)
) (
  input  logic [COLS-1:0] hit_i,
  output logic            any_o,
  output logic            one_o,
  output logic [CW-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int c = COLS - 1; c >= 0; c--) begin
      if (hit_i[c]) idx_o = CW'(c);
    end
  end

  assign any_o = |hit_i;
  assign one_o = any_o && ((hit_i & (hit_i - 1'b1)) == '0);
endmodule

// File: rtl/kpad_mask.sv
module kpad_mask
  import kpad_pkg::*;
#(
  parameter int unsigned MASK_TICKS = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic any_i,
  input  logic one_i,
  output logic fire_o,
  output logic hold_o
);
  localparam int unsigned MW = $clog2(MASK_TICKS + 1);
  localparam logic [MW-1:0] LAST = MW'(MASK_TICKS - 1);

  kpad_state_e   st_q;
  logic [MW-1:0] quiet_q;

  assign fire_o = (st_q == ST_SCAN) && tick_i && one_i;
  assign hold_o = (st_q == ST_MASK) || fire_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_SCAN;
      quiet_q <= '0;
    end else begin
      case (st_q)
        ST_SCAN: if (fire_o) begin
          st_q    <= ST_MASK;
          quiet_q <= '0;
        end
        default: if (tick_i) begin
          if (any_i) quiet_q <= '0;             // retrigger
          else if (quiet_q == LAST) begin
            st_q    <= ST_SCAN;
            quiet_q <= '0;
          end else quiet_q <= quiet_q + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/kpad_scan.sv
module kpad_scan
  import kpad_pkg::*;
#(
  parameter int unsigned SCAN_DIV    = 50000,
  parameter int unsigned MASK_TICKS  = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] col_ni,
  output logic [3:0] row_no_o,
  output logic [3:0] key_o,
  output logic       key_stb_o,
  output logic [7:0] seg_o
);
  localparam int unsigned ROWS = 4;
  localparam int unsigned COLS = 4;
  localparam int unsigned RW   = $clog2(ROWS);
  localparam int unsigned CW   = $clog2(COLS);

  logic [COLS-1:0] sync_q [SYNC_STAGES];
  logic            tick, any_hit, one_hit, fire, hold;
  logic [RW-1:0]   row_idx;
  logic [CW-1:0]   col_idx;
  logic [3:0]      key_q;
  logic            stb_q, vld_q;
  logic [7:0]      seg_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= '1;
      else         sync_q[s] <= (s == 0) ? col_ni : sync_q[(s == 0) ? 0 : s - 1];
    end
  end

  kpad_tick_gen #(.DIV(SCAN_DIV)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  kpad_row_scan #(.ROWS(ROWS)) i_rows (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .hold_i   (hold),
    .row_idx_o(row_idx),
    .row_no_o (row_no_o)
  );

  kpad_col_enc #(.COLS(COLS)) i_cols (
    .hit_i(~sync_q[SYNC_STAGES-1]),
    .any_o(any_hit),
    .one_o(one_hit),
    .idx_o(col_idx)
  );

  kpad_mask #(.MASK_TICKS(MASK_TICKS)) i_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .any_i (any_hit),
    .one_i (one_hit),
    .fire_o(fire),
    .hold_o(hold)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      stb_q <= 1'b0;
      vld_q <= 1'b0;
      seg_q <= SEG_DP_ONLY;
    end else begin
      stb_q <= fire;
      if (fire) begin
        key_q <= {row_idx, col_idx};
        vld_q <= 1'b1;
        seg_q <= hex_to_seg({row_idx, col_idx});
      end else if (!vld_q) begin
        seg_q <= SEG_DP_ONLY;
      end
    end
  end

  assign key_o     = key_q;
  assign key_stb_o = stb_q;
  assign seg_o     = seg_q;
endmodule

// File: rtl/kpad_scan_chk.sv
module kpad_scan_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] row_no_o,
  input logic [3:0] key_o,
  input logic       key_stb_o,
  input logic [7:0] seg_o
);
  p_one_row_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~row_no_o) == 1);

  p_code_row_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_stb_o |-> (row_no_o == ~(4'b0001 << key_o[3:2])));

  p_stb_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_stb_o |=> !key_stb_o);

  p_row_paused_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_stb_o |=> $stable(row_no_o));

  p_seg_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_stb_o |-> !seg_o[7]);

  p_code_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_stb_o |-> ($stable(key_o) && $stable(seg_o)));
endmodule

bind kpad_scan kpad_scan_chk i_kpad_scan_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .row_no_o (row_no_o),
  .key_o    (key_o),
  .key_stb_o(key_stb_o),
  .seg_o    (seg_o)
);

// File: tb/test_kpad_scan.sv
module test_kpad_scan;
  localparam int unsigned DIV  = 4;
  localparam int unsigned MASK = 4;
  localparam int unsigned NV   = 8;
  // {code, expected segments}
  localparam logic [11:0] VEC [NV] = '{
    {4'h0, 8'h3F}, {4'h1, 8'h06}, {4'h8, 8'h7F}, {4'hA, 8'h77},
    {4'h5, 8'h6D}, {4'hF, 8'h71}, {4'h7, 8'h07}, {4'hC, 8'h39}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] col_ni, row_no_o, key_o;
  logic       key_stb_o;
  logic [7:0] seg_o;
  logic [15:0] pressed = '0;
  int n_chk = 0, n_fail = 0, stb_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  kpad_scan #(.SCAN_DIV(DIV), .MASK_TICKS(MASK)) i_kpad_scan (
    .clk_i(clk_i), .rst_ni(rst_ni), .col_ni(col_ni),
    .row_no_o(row_no_o), .key_o(key_o), .key_stb_o(key_stb_o), .seg_o(seg_o)
  );

  // switch matrix model
  always_comb begin
    col_ni = '1;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        if (pressed[r*4+c] && !row_no_o[r]) col_ni[c] = 1'b0;
  end

  always @(negedge clk_i) if (rst_ni && key_stb_o) stb_cnt++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wait_stb(output bit found);
    found = 1'b0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk_i);
      if (key_stb_o) begin found = 1'b1; break; end
    end
  endtask

  initial begin
    bit f;
    int s0;
    logic [3:0] k0, seen;
    cyc(3);
    chk(row_no_o == 4'b1110, "R1 row", 32'(row_no_o), 32'hE);
    chk(key_o == 4'h0 && !key_stb_o, "R1 key", {key_o, 3'b0, key_stb_o}, 0);
    chk(seg_o == 8'h80, "R1/R9 seg", 32'(seg_o), 32'h80);
    rst_ni = 1'b1;
    for (int k = 1; k <= 16; k++) begin
      @(posedge clk_i); @(negedge clk_i);
      chk(row_no_o == ~(4'b0001 << ((k / DIV) % 4)), "R2 scan order",
          32'(row_no_o), 32'(4'(~(4'b0001 << ((k / DIV) % 4)))));
    end
    chk(seg_o == 8'h80, "R9 blank before press", 32'(seg_o), 32'h80);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] code;
      code = VEC[i][11:8];
      s0 = stb_cnt;
      pressed = 16'(1) << code;
      wait_stb(f);
      chk(f, "R4 strobe seen", 32'(f), 1);
      chk(key_o == code, "R3 code", 32'(key_o), 32'(code));
      chk(seg_o == VEC[i][7:0], "R8 segments", 32'(seg_o), 32'(VEC[i][7:0]));
      cyc(1);
      chk(!key_stb_o, "R4 one cycle", 32'(key_stb_o), 0);
      cyc(30);
      chk(row_no_o == ~(4'b0001 << code[3:2]), "R5 row paused",
          32'(row_no_o), 32'(4'(~(4'b0001 << code[3:2]))));
      chk(stb_cnt == s0 + 1, "R6 no repeat while held", 32'(stb_cnt), 32'(s0 + 1));
      pressed = '0;
      cyc(40);
      chk(key_o == code && seg_o == VEC[i][7:0], "R10 held after release",
          {key_o, seg_o}, {code, VEC[i][7:0]});
    end

    // two columns in row 2
    k0 = key_o; s0 = stb_cnt; seen = '0;
    pressed = (16'(1) << 8) | (16'(1) << 11);
    for (int n = 0; n < 80; n++) begin
      @(negedge clk_i);
      seen |= ~row_no_o;
    end
    chk(stb_cnt == s0, "R7 no strobe", 32'(stb_cnt), 32'(s0));
    chk(key_o == k0, "R7 code kept", 32'(key_o), 32'(k0));
    chk(seen == 4'hF, "R7 scan continues", 32'(seen), 32'hF);
    pressed = '0;
    cyc(20);

    // bounce after acceptance
    s0 = stb_cnt;
    pressed = 16'(1) << 6;
    wait_stb(f);
    chk(f && key_o == 4'h6, "R3 key 6", 32'(key_o), 32'h6);
    for (int j = 0; j < 6; j++) begin
      pressed = '0; cyc(1);
      pressed = 16'(1) << 6; cyc(2);
    end
    cyc(20);
    pressed = '0;
    cyc(40);
    chk(stb_cnt == s0 + 1, "R6 bounce masked", 32'(stb_cnt), 32'(s0 + 1));
    chk(stb_cnt == NV + 1, "R4 total strobes", 32'(stb_cnt), 32'(NV + 1));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int n = 0; n < 20000; n++) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=1 exp=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule